// File: doc/BRIEF.md
# Per-Processor GPIO Interrupt Router

This block sits beside a 32-line GPIO bank that is shared by several processors and turns the bank's per-pin signals into interrupts for each processor. The bank supplies two vectors. One is the current, polarity-adjusted input level of every pin. The other carries a one-cycle pulse for every detected edge. For every processor the router keeps an edge-event register and two enable masks, one for edges and one for levels. It combines them into a per-pin request: a pin requests when its level is high and its level enable is set, or when its edge event is pending and its edge enable is set. The requests are then folded, eight pins at a time, into four registered summary lines per processor.

The variant is picked at elaboration. In the per-processor variant, each processor owns a private event register and private masks, all in a dedicated register window, and it acknowledges its events without disturbing the others. In the dual variant, a single event register in the main window is shared, and only the two mask pairs are duplicated, at fixed offsets. Software acknowledges an event by writing 0 to its bit. Register reads are combinational from the address and window inputs.

Top module: `gpio_pcpu_irq_router`

## Requirements
- R1: After reset every event and mask register reads zero and every summary output is low, even with all pin levels high.
- R2: In the per-processor variant (`reg_win`=1), processor n's event register is at offset n*4, its edge mask at 0x10+n*4 and its level mask at 0x20+n*4. Each mask is written whole and reads back the value written.
- R3: In the per-processor variant, an edge pulse on a pin sets that pin's event bit in every processor's event register.
- R4: Writing an event register clears the bits written as 0 and leaves the bits written as 1 unchanged. In the per-processor variant only the addressed processor's copy changes.
- R5: An edge pulse that arrives in the same cycle as a write that clears its bit leaves the bit set.
- R6: A processor's pin request is (level AND level mask) OR (event AND edge mask). A level request is not latched: it follows the pin level.
- R7: Summary output bit c*4+g is the OR of processor c's requests for pins 8g to 8g+7. It is registered, so it changes on the clock edge after the request changes.
- R8: In the dual variant (`reg_win`=0), processor 0's edge and level masks are at 0x18 and 0x1C, and processor 1's are at 0x30 and 0x34.
- R9: In the dual variant, one event register at 0x14 serves both processors. Clearing a bit there removes the request from both processors, and summary outputs for processors 2 and above stay low.
- R10: A read of an unmapped offset returns zero and a write to it changes nothing. Unmapped offsets include the main window in the per-processor variant, the per-processor window in the dual variant, misaligned offsets and gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_level | input | N_PINS | Polarity-adjusted pin levels from the bank |
| pin_edge | input | N_PINS | One-cycle edge pulses from the bank |
| reg_wen | input | 1 | Register write strobe |
| reg_win | input | 1 | Window select: 0 main window, 1 per-processor window |
| reg_addr | input | 8 | Byte offset within the selected window |
| reg_wdata | input | N_PINS | Write data |
| reg_rdata | output | N_PINS | Read data for the current window and offset |
| irq_o | output | N_CPU*N_PINS/8 | Summary lines, bit c*4+g for processor c, pin group g |

## Verification
The bench targets the acknowledge path. It clears one processor's copy of a pending event and checks that the other copies survive, which a design with one shared event register would fail in the per-processor variant. It writes a clear in the same cycle as a fresh edge on the same pin, where a design that gives the write priority would drop the event. Requests on pins 9 and 24 must appear on exactly the right group line and processor, which catches off-by-one slicing. The bench also writes all ones into gap, misaligned and wrong-window offsets and checks that nothing was aliased.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    typedef enum logic {
        ROUTE_PER_CPU = 1'b0,
        ROUTE_DUAL    = 1'b1
    } route_mode_e;

    typedef enum logic [1:0] {
        KIND_NONE  = 2'd0,
        KIND_CAUSE = 2'd1,
        KIND_EMASK = 2'd2,
        KIND_LMASK = 2'd3
    } reg_kind_e;

    localparam int unsigned ADDR_W  = 8;
    localparam int unsigned MAX_CPU = 4;

    // dual-variant main window offsets
    localparam logic [ADDR_W-1:0] DUAL_CAUSE  = 8'h14;
    localparam logic [ADDR_W-1:0] DUAL_EMASK0 = 8'h18;
    localparam logic [ADDR_W-1:0] DUAL_LMASK0 = 8'h1C;
    localparam logic [ADDR_W-1:0] DUAL_EMASK1 = 8'h30;
    localparam logic [ADDR_W-1:0] DUAL_LMASK1 = 8'h34;

    // per-processor window: bits [5:4] select the register kind
    localparam logic [1:0] PCPU_SEL_CAUSE = 2'd0;
    localparam logic [1:0] PCPU_SEL_EMASK = 2'd1;
    localparam logic [1:0] PCPU_SEL_LMASK = 2'd2;

endpackage

// File: rtl/gpio_irq_addr_dec.sv
module gpio_irq_addr_dec
    import gpio_irq_pkg::*;
#(
    parameter route_mode_e MODE  = ROUTE_PER_CPU,
    parameter int unsigned N_CPU = 4
) (
    input  logic                   wen,
    input  logic                   win,
    input  logic [ADDR_W-1:0]      addr,
    output reg_kind_e              hit_kind,
    output logic [1:0]             hit_cpu,
    output logic [N_CPU-1:0]       cause_we,
    output logic [N_CPU-1:0]       emask_we,
    output logic [N_CPU-1:0]       lmask_we
);

    always_comb begin
        hit_kind = KIND_NONE;
        hit_cpu  = 2'd0;
        if (MODE == ROUTE_PER_CPU) begin
            if (win && (addr[7:6] == 2'b00) && (addr[1:0] == 2'b00) &&
                (int'(addr[3:2]) < int'(N_CPU))) begin
                hit_cpu = addr[3:2];
                case (addr[5:4])
                    PCPU_SEL_CAUSE: hit_kind = KIND_CAUSE;
                    PCPU_SEL_EMASK: hit_kind = KIND_EMASK;
                    PCPU_SEL_LMASK: hit_kind = KIND_LMASK;
                    default:        hit_kind = KIND_NONE;
                endcase
            end
        end else begin
            if (!win) begin
                case (addr)
                    DUAL_CAUSE:  begin hit_kind = KIND_CAUSE; hit_cpu = 2'd0; end
                    DUAL_EMASK0: begin hit_kind = KIND_EMASK; hit_cpu = 2'd0; end
                    DUAL_LMASK0: begin hit_kind = KIND_LMASK; hit_cpu = 2'd0; end
                    DUAL_EMASK1: begin hit_kind = KIND_EMASK; hit_cpu = 2'd1; end
                    DUAL_LMASK1: begin hit_kind = KIND_LMASK; hit_cpu = 2'd1; end
                    default:     hit_kind = KIND_NONE;
                endcase
            end
        end
    end

    always_comb begin
        for (int c = 0; c < int'(N_CPU); c++) begin
            cause_we[c] = wen && (hit_kind == KIND_CAUSE) && (hit_cpu == 2'(c));
            emask_we[c] = wen && (hit_kind == KIND_EMASK) && (hit_cpu == 2'(c));
            lmask_we[c] = wen && (hit_kind == KIND_LMASK) && (hit_cpu == 2'(c));
        end
    end

endmodule

// File: rtl/gpio_irq_cpu_slice.sv
module gpio_irq_cpu_slice #(
    parameter int unsigned N_PINS    = 32,
    parameter bit          OWN_CAUSE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] edge_evt,
    input  logic [N_PINS-1:0] level_in,
    input  logic              cause_we,
    input  logic              emask_we,
    input  logic              lmask_we,
    input  logic [N_PINS-1:0] wdata,
    input  logic [N_PINS-1:0] shared_cause,
    output logic [N_PINS-1:0] cause_o,
    output logic [N_PINS-1:0] emask_o,
    output logic [N_PINS-1:0] lmask_o,
    output logic [N_PINS-1:0] req_o
);

    typedef struct packed {
        logic [N_PINS-1:0] cause;
        logic [N_PINS-1:0] emask;
        logic [N_PINS-1:0] lmask;
    } slice_st_t;

    slice_st_t st_d, st_q;
    logic [N_PINS-1:0] keep_d;
    logic [N_PINS-1:0] cause_eff_d;

    always_comb begin
        st_d   = st_q;
        keep_d = cause_we ? wdata : '1;
        if (OWN_CAUSE) begin
            // a fresh edge outranks a clear in the same cycle
            st_d.cause = (st_q.cause & keep_d) | edge_evt;
        end else begin
            st_d.cause = '0;
        end
        if (emask_we) st_d.emask = wdata;
        if (lmask_we) st_d.lmask = wdata;
        cause_eff_d = OWN_CAUSE ? st_q.cause : shared_cause;
        req_o       = (level_in & st_q.lmask) | (cause_eff_d & st_q.emask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cause_o = st_q.cause;
    assign emask_o = st_q.emask;
    assign lmask_o = st_q.lmask;

    assert_cause_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cause_we && (edge_evt == '0)) |=> $stable(cause_o));

    assert_write_never_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cause_we |=> ((cause_o & ~$past(cause_o) & ~$past(edge_evt)) == '0));

    assert_emask_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !emask_we |=> $stable(emask_o));

    assert_lmask_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !lmask_we |=> $stable(lmask_o));

    generate
        if (OWN_CAUSE) begin : g_own
            assert_edge_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (edge_evt != '0) |=> ((cause_o & $past(edge_evt)) == $past(edge_evt)));
        end
    endgenerate

endmodule

// File: rtl/gpio_irq_group_or.sv
module gpio_irq_group_or #(
    parameter int unsigned N_PINS = 32,
    parameter int unsigned GROUP  = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_PINS-1:0]          req,
    output logic [N_PINS/GROUP-1:0]    irq_o
);

    localparam int unsigned N_GROUPS = N_PINS / GROUP;

    logic [N_GROUPS-1:0] sum_d, sum_q;

    generate
        for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
            always_comb sum_d[g] = |req[g*GROUP +: GROUP];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sum_q <= '0;
        else        sum_q <= sum_d;
    end

    assign irq_o = sum_q;

    assert_quiet_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req == '0) |=> (irq_o == '0));

endmodule

// File: rtl/gpio_pcpu_irq_router.sv
module gpio_pcpu_irq_router
    import gpio_irq_pkg::*;
#(
    parameter route_mode_e MODE   = ROUTE_PER_CPU,
    parameter int unsigned N_CPU  = 4,
    parameter int unsigned N_PINS = 32,
    parameter int unsigned GROUP  = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [N_PINS-1:0]                pin_level,
    input  logic [N_PINS-1:0]                pin_edge,
    input  logic                             reg_wen,
    input  logic                             reg_win,
    input  logic [7:0]                       reg_addr,
    input  logic [N_PINS-1:0]                reg_wdata,
    output logic [N_PINS-1:0]                reg_rdata,
    output logic [N_CPU*(N_PINS/GROUP)-1:0]  irq_o
);

    localparam int unsigned N_GROUPS = N_PINS / GROUP;

    reg_kind_e                       hit_kind;
    logic [1:0]                      hit_cpu;
    logic [N_CPU-1:0]                cause_we, emask_we, lmask_we;
    logic [N_CPU-1:0][N_PINS-1:0]    cause_all, emask_all, lmask_all, req_all;
    logic [N_PINS-1:0]               shared_cause;

    gpio_irq_addr_dec #(
        .MODE  (MODE),
        .N_CPU (N_CPU)
    ) u_dec (
        .wen      (reg_wen),
        .win      (reg_win),
        .addr     (reg_addr),
        .hit_kind (hit_kind),
        .hit_cpu  (hit_cpu),
        .cause_we (cause_we),
        .emask_we (emask_we),
        .lmask_we (lmask_we)
    );

    assign shared_cause = cause_all[0];

    generate
        for (genvar c = 0; c < N_CPU; c++) begin : g_cpu
            gpio_irq_cpu_slice #(
                .N_PINS    (N_PINS),
                .OWN_CAUSE ((MODE == ROUTE_PER_CPU) || (c == 0))
            ) u_slice (
                .clk          (clk),
                .rst_n        (rst_n),
                .edge_evt     (pin_edge),
                .level_in     (pin_level),
                .cause_we     (cause_we[c]),
                .emask_we     (emask_we[c]),
                .lmask_we     (lmask_we[c]),
                .wdata        (reg_wdata),
                .shared_cause (shared_cause),
                .cause_o      (cause_all[c]),
                .emask_o      (emask_all[c]),
                .lmask_o      (lmask_all[c]),
                .req_o        (req_all[c])
            );

            gpio_irq_group_or #(
                .N_PINS (N_PINS),
                .GROUP  (GROUP)
            ) u_grp (
                .clk   (clk),
                .rst_n (rst_n),
                .req   (req_all[c]),
                .irq_o (irq_o[c*N_GROUPS +: N_GROUPS])
            );

            assert_masked_off_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
                ((emask_all[c] == '0) && (lmask_all[c] == '0))
                |=> (irq_o[c*N_GROUPS +: N_GROUPS] == '0));
        end
    endgenerate

    always_comb begin
        reg_rdata = '0;
        for (int c = 0; c < int'(N_CPU); c++) begin
            if (hit_cpu == 2'(c)) begin
                case (hit_kind)
                    KIND_CAUSE: reg_rdata = cause_all[c];
                    KIND_EMASK: reg_rdata = emask_all[c];
                    KIND_LMASK: reg_rdata = lmask_all[c];
                    default:    reg_rdata = '0;
                endcase
            end
        end
    end

    assert_single_target_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cause_we, emask_we, lmask_we}));

    assert_unmapped_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wen && (hit_kind == KIND_NONE))
        |=> ($stable(emask_all) && $stable(lmask_all)));

    assert_unmapped_reads_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_kind == KIND_NONE) |-> (reg_rdata == '0));

endmodule

// File: tb/tb_gpio_pcpu_irq_router.sv
module tb_gpio_pcpu_irq_router;
    import gpio_irq_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [31:0] p_level, p_edge, p_wdata, p_rdata;
    logic        p_wen, p_win;
    logic [7:0]  p_addr;
    logic [15:0] p_irq;

    logic [31:0] d_level, d_edge, d_wdata, d_rdata;
    logic        d_wen, d_win;
    logic [7:0]  d_addr;
    logic [15:0] d_irq;

    int n_checks = 0;
    int n_fails  = 0;

    gpio_pcpu_irq_router #(.MODE(ROUTE_PER_CPU), .N_CPU(4)) dut (
        .clk(clk), .rst_n(rst_n), .pin_level(p_level), .pin_edge(p_edge),
        .reg_wen(p_wen), .reg_win(p_win), .reg_addr(p_addr),
        .reg_wdata(p_wdata), .reg_rdata(p_rdata), .irq_o(p_irq));

    gpio_pcpu_irq_router #(.MODE(ROUTE_DUAL), .N_CPU(4)) dut_dual (
        .clk(clk), .rst_n(rst_n), .pin_level(d_level), .pin_edge(d_edge),
        .reg_wen(d_wen), .reg_win(d_win), .reg_addr(d_addr),
        .reg_wdata(d_wdata), .reg_rdata(d_rdata), .irq_o(d_irq));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        p_level = '0; p_edge = '0; p_wdata = '0; p_wen = 0; p_win = 0; p_addr = '0;
        d_level = '0; d_edge = '0; d_wdata = '0; d_wen = 0; d_win = 0; d_addr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input bit dual, input bit win, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        if (dual) begin d_win = win; d_addr = a; d_wdata = d; d_wen = 1; end
        else      begin p_win = win; p_addr = a; p_wdata = d; p_wen = 1; end
        @(negedge clk);
        d_wen = 0; p_wen = 0;
    endtask

    task automatic rd(input bit dual, input bit win, input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        if (dual) begin d_win = win; d_addr = a; #1 d = d_rdata; end
        else      begin p_win = win; p_addr = a; #1 d = p_rdata; end
    endtask

    task automatic pulse(input bit dual, input logic [31:0] m);
        @(negedge clk);
        if (dual) d_edge = m; else p_edge = m;
        @(negedge clk);
        d_edge = '0; p_edge = '0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        do_reset();
        p_level = '1;
        repeat (2) @(negedge clk);
        for (int c = 0; c < 4; c++) begin
            rd(0, 1, 8'(c*4), v);        chk("R1 cause", v, 0);
            rd(0, 1, 8'(8'h10 + c*4), v); chk("R1 emask", v, 0);
            rd(0, 1, 8'(8'h20 + c*4), v); chk("R1 lmask", v, 0);
        end
        chk("R1 irq", {16'h0, p_irq}, 0);
    endtask

    task automatic t_map();
        logic [31:0] v;
        do_reset();
        for (int c = 0; c < 4; c++) begin
            wr(0, 1, 8'(8'h10 + c*4), 32'hA5000000 ^ (32'h0101 * c));
            wr(0, 1, 8'(8'h20 + c*4), 32'h005A0000 ^ (32'h1000 * (c+1)));
        end
        for (int c = 0; c < 4; c++) begin
            rd(0, 1, 8'(8'h10 + c*4), v); chk("R2 emask readback", v, 32'hA5000000 ^ (32'h0101 * c));
            rd(0, 1, 8'(8'h20 + c*4), v); chk("R2 lmask readback", v, 32'h005A0000 ^ (32'h1000 * (c+1)));
            rd(0, 1, 8'(c*4), v);         chk("R2 cause untouched", v, 0);
        end
    endtask

    task automatic t_edge_clear();
        logic [31:0] v;
        do_reset();
        pulse(0, 32'h000000F0);
        for (int c = 0; c < 4; c++) begin
            rd(0, 1, 8'(c*4), v); chk("R3 every copy set", v, 32'h000000F0);
        end
        wr(0, 1, 8'h04, 32'hFFFFFF7F);
        for (int c = 0; c < 4; c++) begin
            rd(0, 1, 8'(c*4), v);
            chk("R4 clear only addressed copy", v, (c == 1) ? 32'h00000070 : 32'h000000F0);
        end
    endtask

    task automatic t_edge_wins();
        logic [31:0] v;
        do_reset();
        pulse(0, 32'h00000028);
        @(negedge clk);
        p_win = 1; p_addr = 8'h00; p_wdata = 32'h0; p_wen = 1; p_edge = 32'h00000008;
        @(negedge clk);
        p_wen = 0; p_edge = '0;
        rd(0, 1, 8'h00, v); chk("R5 edge outranks clear", v, 32'h00000008);
        rd(0, 1, 8'h08, v); chk("R5 other copy keeps both", v, 32'h00000028);
    endtask

    task automatic t_groups();
        do_reset();
        wr(0, 1, 8'h10, 32'h00000200);
        wr(0, 1, 8'h18, 32'h01000000);
        pulse(0, 32'h01000200);
        @(negedge clk);
        chk("R7 group mapping", {16'h0, p_irq}, 32'h00000802);
        wr(0, 1, 8'h00, 32'hFFFFFDFF);
        @(negedge clk);
        chk("R6 edge request gone after ack", {16'h0, p_irq}, 32'h00000800);
    endtask

    task automatic t_level();
        logic [31:0] v;
        do_reset();
        wr(0, 1, 8'h2C, 32'h00010000);
        @(negedge clk);
        p_level = 32'h00010000;
        #1 chk("R7 no output before edge", {16'h0, p_irq}, 0);
        @(negedge clk);
        chk("R6 level request", {16'h0, p_irq}, 32'h00004000);
        p_level = '0;
        @(negedge clk);
        chk("R6 level not latched", {16'h0, p_irq}, 0);
        rd(0, 1, 8'h0C, v); chk("R6 level leaves cause clear", v, 0);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        do_reset();
        wr(0, 1, 8'h30, '1);
        wr(0, 1, 8'h3C, '1);
        wr(0, 1, 8'h12, '1);
        wr(0, 0, 8'h18, '1);
        wr(0, 1, 8'h40, '1);
        rd(0, 1, 8'h30, v); chk("R10 gap reads zero", v, 0);
        rd(0, 1, 8'h12, v); chk("R10 misaligned reads zero", v, 0);
        rd(0, 0, 8'h18, v); chk("R10 main window reads zero", v, 0);
        for (int c = 0; c < 4; c++) begin
            rd(0, 1, 8'(8'h10 + c*4), v); chk("R10 emask unaltered", v, 0);
            rd(0, 1, 8'(8'h20 + c*4), v); chk("R10 lmask unaltered", v, 0);
        end
        p_level = '1;
        repeat (2) @(negedge clk);
        chk("R10 no irq after ignored writes", {16'h0, p_irq}, 0);
    endtask

    task automatic t_dual_map();
        logic [31:0] v;
        do_reset();
        wr(1, 0, 8'h18, 32'h11);
        wr(1, 0, 8'h1C, 32'h22);
        wr(1, 0, 8'h30, 32'h44);
        wr(1, 0, 8'h34, 32'h88);
        rd(1, 0, 8'h18, v); chk("R8 cpu0 edge mask", v, 32'h11);
        rd(1, 0, 8'h1C, v); chk("R8 cpu0 level mask", v, 32'h22);
        rd(1, 0, 8'h30, v); chk("R8 cpu1 edge mask", v, 32'h44);
        rd(1, 0, 8'h34, v); chk("R8 cpu1 level mask", v, 32'h88);
        wr(1, 1, 8'h10, '1);
        rd(1, 1, 8'h10, v); chk("R10 dual per-cpu window reads zero", v, 0);
        rd(1, 0, 8'h18, v); chk("R10 dual mask unaltered", v, 32'h11);
    endtask

    task automatic t_dual_shared();
        logic [31:0] v;
        do_reset();
        wr(1, 0, 8'h18, 32'h000000FF);
        wr(1, 0, 8'h30, 32'h0000FF00);
        pulse(1, 32'h00000202);
        @(negedge clk);
        rd(1, 0, 8'h14, v); chk("R9 shared cause", v, 32'h00000202);
        chk("R9 both cpus fire", {16'h0, d_irq}, 32'h00000021);
        wr(1, 0, 8'h14, 32'hFFFFFDFF);
        @(negedge clk);
        chk("R9 ack removes cpu1 request", {16'h0, d_irq}, 32'h00000001);
        rd(1, 0, 8'h14, v); chk("R9 cause after ack", v, 32'h00000002);
        d_level = '1;
        repeat (2) @(negedge clk);
        chk("R9 cpus 2 and 3 silent", {16'h0, d_irq[15:8]}, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL R1 watchdog actual=timeout expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        t_reset();
        t_map();
        t_edge_clear();
        t_edge_wins();
        t_groups();
        t_level();
        t_unmapped();
        t_dual_map();
        t_dual_shared();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule